// File: doc/BRIEF.md
# Interrupt Destination Matcher and Selector

This block takes an interrupt command written as two 32-bit words and works out which of `N_TGT` target units should receive it. The high word carries only the 8-bit destination. The low word carries the vector, the delivery mode, the destination addressing mode, the level and trigger bits and a two-bit shorthand selector. Writing the low word starts a dispatch. A few cycles later the block gives a single-cycle pulse with a delivery mask, one bit per target, and the decoded command fields.

Each target brings in a physical ID, a logical ID, a model bit that chooses flat or cluster logical matching, and an enable flag. Physical, flat-logical and cluster-logical addressing are supported, along with the self, all and all-but-self shorthands. In lowest-priority delivery the matching targets are narrowed to a single enabled one. A rotating pointer does this selection, so successive commands spread over the eligible targets.

The controller is a four-state machine:
- `ST_IDLE` waits for a low-word write (transition IDLE→MATCH).
- `ST_MATCH` registers the match bitmap. It goes on to ARB for lowest-priority delivery and to SEND for every other mode.
- `ST_ARB` picks the round-robin winner and moves the pointer (transition ARB→SEND).
- `ST_SEND` drives the pulse and returns to IDLE (transition SEND→IDLE).

Top module: `irq_dest_router`

## Requirements
- R1: During the delivery pulse the outputs carry fields of the stored low word: `dlv_vector` is bits [7:0], `dlv_mode` is bits [10:8], `dlv_level` is bit 14 and `dlv_trigger` is bit 15. The destination is high-word bits [31:24].
- R2: Physical addressing applies when low-word bit 11 is 0 and the shorthand is 0. A target's mask bit is set when the destination is 0xFF or equals that target's physical ID.
- R3: Logical addressing applies when bit 11 is 1 and the shorthand is 0. A target whose model bit is 0 (flat) matches when (logical ID AND destination) is nonzero.
- R4: In logical addressing, a target whose model bit is 1 (cluster) matches when two conditions both hold: the upper nibbles of the logical ID and the destination are equal, and (logical ID AND destination AND 0xF) is nonzero.
- R5: Shorthand bits [19:18] behave as follows: 1 selects only the target numbered `src_idx`, 2 selects every target, and 3 selects every target except `src_idx`. For shorthands 1 to 3 the destination and bit 11 are ignored. In all modes other than lowest-priority, the enable flags do not affect the mask.
- R6: Lowest-priority delivery is mode 3'b001. It delivers to exactly one target: the first target that both matches and is enabled, scanning upward from the pointer plus one with wrap-around. The pointer then takes the winner's index. After reset the pointer is `N_TGT-1`, so the first scan begins at target 0.
- R7: An empty result gives no pulse. This covers a lowest-priority command with no enabled matching target, which also leaves the pointer unchanged, and any other command that matches no target.
- R8: A low-word write sampled while idle starts a dispatch. `dlv_valid` is high for exactly one cycle. For a non-lowest-priority mode it goes high after the second rising edge following the sampling edge; for lowest-priority mode it goes high after the third.
- R9: Low-word bit 12 always reads back as 0. The high word reads back only bits [31:24], and all its other bits read as 0.
- R10: Writes to either word while a dispatch is in progress are ignored. The readback values and the command being dispatched stay unchanged.
- R11: After reset, both readback words are 0 and `dlv_valid` and `dlv_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_lo_wr | input | 1 | Write strobe for the low word; starts a dispatch |
| cmd_hi_wr | input | 1 | Write strobe for the high word |
| wr_data | input | 32 | Write data shared by both words |
| src_idx | input | IDX_W | Index of the issuing unit, used by the self and all-but-self shorthands |
| tgt_phys_id | input | 8*N_TGT | Physical IDs, target i in bits [8i+7:8i] |
| tgt_log_id | input | 8*N_TGT | Logical IDs, target i in bits [8i+7:8i] |
| tgt_cluster | input | N_TGT | Logical model per target: 1 cluster, 0 flat |
| tgt_enable | input | N_TGT | Target enabled for lowest-priority selection |
| cmd_lo_rd | output | 32 | Stored low word, bit 12 forced to 0 |
| cmd_hi_rd | output | 32 | Stored high word, only bits [31:24] kept |
| dlv_valid | output | 1 | Single-cycle delivery pulse |
| dlv_mask | output | N_TGT | Targets receiving the interrupt, 0 outside the pulse |
| dlv_vector | output | 8 | Decoded vector |
| dlv_mode | output | 3 | Decoded delivery mode |
| dlv_level | output | 1 | Decoded level-assert bit |
| dlv_trigger | output | 1 | Decoded trigger-mode bit |

## Verification
The fixed target set mixes flat and cluster models and includes one disabled target.

Addressing is tested with several kinds of command:
- Physical commands aimed at one ID, at the broadcast value and at an absent ID show whether the equality compare, the 0xFF case and the empty-mask suppression work.
- Logical destinations are chosen so that flat and cluster targets disagree, which shows the nibble compare acting separately from the AND test.
- The three shorthands, sent with a destination that would otherwise match nothing, show that the destination field is really bypassed.

A run of lowest-priority commands walks the pointer around the ring, across the disabled target and through a wrap. It also includes a command whose only candidate is disabled, and the command after it shows that the pointer did not move.

Writes issued while a dispatch is in progress show whether the busy states guard the command registers.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_ARB   = 2'd2,
        ST_SEND  = 2'd3
    } state_e;

    localparam logic [2:0] DM_LOWEST = 3'b001;
    localparam int         STATUS_BIT = 12;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       logical;
        logic       level;
        logic       trigger;
        shorthand_e shorthand;
        logic [7:0] dest;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [31:0] lo, input logic [7:0] dest);
        cmd_t c;
        c.vector    = lo[7:0];
        c.mode      = lo[10:8];
        c.logical   = lo[11];
        c.level     = lo[14];
        c.trigger   = lo[15];
        c.shorthand = shorthand_e'(lo[19:18]);
        c.dest      = dest;
        return c;
    endfunction

endpackage

// File: rtl/irq_cmd_regs.sv
module irq_cmd_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_we,
    input  logic        hi_we,
    input  logic [31:0] wdata,
    output logic [31:0] lo_q,
    output logic [7:0]  dest_q
);
    import irq_route_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            dest_q <= '0;
        end else begin
            if (lo_we) begin
                lo_q             <= wdata;
                lo_q[STATUS_BIT] <= 1'b0;
            end
            if (hi_we) begin
                dest_q <= wdata[31:24];
            end
        end
    end

endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
    parameter int N_TGT = 4,
    parameter int ID_W  = 8,
    parameter int IDX_W = 2
) (
    input  logic                    logical,
    input  logic [1:0]              shorthand,
    input  logic [ID_W-1:0]         dest,
    input  logic [IDX_W-1:0]        src_idx,
    input  logic [N_TGT*ID_W-1:0]   phys_id,
    input  logic [N_TGT*ID_W-1:0]   log_id,
    input  logic [N_TGT-1:0]        cluster,
    output logic [N_TGT-1:0]        hit
);
    import irq_route_pkg::*;

    localparam int NIB = ID_W / 2;

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        logic [ID_W-1:0] pid;
        logic [ID_W-1:0] lid;
        logic            is_self;
        logic            phys_hit;
        logic            flat_hit;
        logic            clus_hit;
        logic            addr_hit;

        assign pid      = phys_id[i*ID_W +: ID_W];
        assign lid      = log_id[i*ID_W +: ID_W];
        assign is_self  = (IDX_W'(i) == src_idx);
        assign phys_hit = (&dest) || (dest == pid);
        assign flat_hit = |(lid & dest);
        assign clus_hit = (lid[ID_W-1:NIB] == dest[ID_W-1:NIB]) &&
                          (|(lid[NIB-1:0] & dest[NIB-1:0]));
        assign addr_hit = !logical ? phys_hit :
                          (cluster[i] ? clus_hit : flat_hit);

        always_comb begin
            unique case (shorthand_e'(shorthand))
                SH_NONE:   hit[i] = addr_hit;
                SH_SELF:   hit[i] = is_self;
                SH_ALL:    hit[i] = 1'b1;
                SH_OTHERS: hit[i] = !is_self;
                default:   hit[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int N_TGT = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_TGT-1:0] cand,
    input  logic [IDX_W-1:0] last_idx,
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output logic [N_TGT-1:0] win_onehot
);

    always_comb begin
        found   = 1'b0;
        win_idx = last_idx;
        for (int k = 1; k <= N_TGT; k++) begin
            int idx;
            idx = int'(last_idx) + k;
            if (idx >= N_TGT) begin
                idx = idx - N_TGT;
            end
            if (!found && cand[idx]) begin
                found   = 1'b1;
                win_idx = IDX_W'(idx);
            end
        end
    end

    always_comb begin
        win_onehot = '0;
        if (found) begin
            win_onehot[win_idx] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router #(
    parameter int N_TGT = 4,
    parameter int ID_W  = 8,
    parameter int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_lo_wr,
    input  logic                  cmd_hi_wr,
    input  logic [31:0]           wr_data,
    input  logic [IDX_W-1:0]      src_idx,
    input  logic [N_TGT*ID_W-1:0] tgt_phys_id,
    input  logic [N_TGT*ID_W-1:0] tgt_log_id,
    input  logic [N_TGT-1:0]      tgt_cluster,
    input  logic [N_TGT-1:0]      tgt_enable,
    output logic [31:0]           cmd_lo_rd,
    output logic [31:0]           cmd_hi_rd,
    output logic                  dlv_valid,
    output logic [N_TGT-1:0]      dlv_mask,
    output logic [7:0]            dlv_vector,
    output logic [2:0]            dlv_mode,
    output logic                  dlv_level,
    output logic                  dlv_trigger
);
    import irq_route_pkg::*;

    localparam logic [IDX_W-1:0] PTR_INIT = IDX_W'(N_TGT - 1);

    state_e            state_q;
    state_e            state_d;
    logic [31:0]       lo_q;
    logic [7:0]        dest_q;
    cmd_t              cmd;
    logic              idle;
    logic              is_lowest;
    logic [N_TGT-1:0]  hit;
    logic [N_TGT-1:0]  hit_q;
    logic [N_TGT-1:0]  out_q;
    logic [IDX_W-1:0]  ptr_q;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic [N_TGT-1:0]  pick_onehot;

    assign idle      = (state_q == ST_IDLE);
    assign cmd       = unpack_cmd(lo_q, dest_q);
    assign is_lowest = (cmd.mode == DM_LOWEST);

    irq_cmd_regs i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .lo_we  (cmd_lo_wr && idle),
        .hi_we  (cmd_hi_wr && idle),
        .wdata  (wr_data),
        .lo_q   (lo_q),
        .dest_q (dest_q)
    );

    irq_dest_match #(
        .N_TGT (N_TGT),
        .ID_W  (ID_W),
        .IDX_W (IDX_W)
    ) i_match (
        .logical   (cmd.logical),
        .shorthand (cmd.shorthand),
        .dest      (cmd.dest[ID_W-1:0]),
        .src_idx   (src_idx),
        .phys_id   (tgt_phys_id),
        .log_id    (tgt_log_id),
        .cluster   (tgt_cluster),
        .hit       (hit)
    );

    irq_rr_pick #(
        .N_TGT (N_TGT),
        .IDX_W (IDX_W)
    ) i_pick (
        .cand       (hit_q & tgt_enable),
        .last_idx   (ptr_q),
        .found      (pick_found),
        .win_idx    (pick_idx),
        .win_onehot (pick_onehot)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_lo_wr) state_d = ST_MATCH;
            ST_MATCH: state_d = is_lowest ? ST_ARB : ST_SEND;
            ST_ARB:   state_d = ST_SEND;
            ST_SEND:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath registers advanced by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= '0;
            out_q <= '0;
            ptr_q <= PTR_INIT;
        end else begin
            unique case (state_q)
                ST_MATCH: begin
                    hit_q <= hit;
                    out_q <= is_lowest ? '0 : hit;
                end
                ST_ARB: begin
                    out_q <= pick_onehot;
                    if (pick_found) begin
                        ptr_q <= pick_idx;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        dlv_valid   = 1'b0;
        dlv_mask    = '0;
        unique case (state_q)
            ST_SEND: begin
                dlv_valid = |out_q;
                dlv_mask  = out_q;
            end
            default: begin
            end
        endcase
        dlv_vector  = cmd.vector;
        dlv_mode    = cmd.mode;
        dlv_level   = cmd.level;
        dlv_trigger = cmd.trigger;
        cmd_lo_rd   = lo_q;
        cmd_hi_rd   = {dest_q, 24'h0};
    end

endmodule

// File: rtl/irq_dest_router_chk.sv
module irq_dest_router_chk #(
    parameter int N_TGT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_lo_wr,
    input logic              cmd_hi_wr,
    input logic              dlv_valid,
    input logic [N_TGT-1:0]  dlv_mask,
    input logic [2:0]        dlv_mode,
    input logic [N_TGT-1:0]  tgt_enable,
    input logic [31:0]       cmd_lo_rd,
    input logic [31:0]       cmd_hi_rd
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> !dlv_valid); // R8

    AST_LOWEST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 3'b001) |-> ($countones(dlv_mask) == 1)); // R6

    AST_LOWEST_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 3'b001) |-> ((dlv_mask & ~tgt_enable) == '0)); // R6

    AST_EMPTY_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_mask != '0)); // R7

    AST_QUIET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !dlv_valid |-> (dlv_mask == '0)); // R7

    AST_HI_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hi_rd[23:0] == 24'h0); // R9

    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lo_rd[12] == 1'b0); // R9

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && (cmd_lo_wr || cmd_hi_wr)) |=> ($stable(cmd_lo_rd) && $stable(cmd_hi_rd))); // R10

endmodule

bind irq_dest_router irq_dest_router_chk #(.N_TGT(N_TGT)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_lo_wr  (cmd_lo_wr),
    .cmd_hi_wr  (cmd_hi_wr),
    .dlv_valid  (dlv_valid),
    .dlv_mask   (dlv_mask),
    .dlv_mode   (dlv_mode),
    .tgt_enable (tgt_enable),
    .cmd_lo_rd  (cmd_lo_rd),
    .cmd_hi_rd  (cmd_hi_rd)
);

// File: tb/test_irq_dest_router.sv
`timescale 1ns/1ps
module test_irq_dest_router;

    localparam int N  = 4;
    localparam int IW = 2;
    localparam int NV = 17;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_lo_wr = 1'b0;
    logic            cmd_hi_wr = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [IW-1:0]   src_idx = 2'd1;
    logic [N*8-1:0]  tgt_phys_id = {8'h13, 8'h12, 8'h11, 8'h10};
    logic [N*8-1:0]  tgt_log_id  = {8'h32, 8'h31, 8'h02, 8'h01};
    logic [N-1:0]    tgt_cluster = 4'b1100;
    logic [N-1:0]    tgt_enable  = 4'b1011;
    logic [31:0]     cmd_lo_rd;
    logic [31:0]     cmd_hi_rd;
    logic            dlv_valid;
    logic [N-1:0]    dlv_mask;
    logic [7:0]      dlv_vector;
    logic [2:0]      dlv_mode;
    logic            dlv_level;
    logic            dlv_trigger;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_dest_router #(.N_TGT(N)) i_irq_dest_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_lo_wr   (cmd_lo_wr),
        .cmd_hi_wr   (cmd_hi_wr),
        .wr_data     (wr_data),
        .src_idx     (src_idx),
        .tgt_phys_id (tgt_phys_id),
        .tgt_log_id  (tgt_log_id),
        .tgt_cluster (tgt_cluster),
        .tgt_enable  (tgt_enable),
        .cmd_lo_rd   (cmd_lo_rd),
        .cmd_hi_rd   (cmd_hi_rd),
        .dlv_valid   (dlv_valid),
        .dlv_mask    (dlv_mask),
        .dlv_vector  (dlv_vector),
        .dlv_mode    (dlv_mode),
        .dlv_level   (dlv_level),
        .dlv_trigger (dlv_trigger)
    );

    // {low word, high word, expected mask}; targets: phys 10..13,
    // logical 01,02 flat and 31,32 cluster, src 1, target 2 disabled
    localparam logic [67:0] VEC [NV] = '{
        {32'h0000_1040, 32'h12AB_CDEF, 4'b0100}, // R2 single ID, status bit set
        {32'h0000_0041, 32'hFF00_0000, 4'b1111}, // R2 broadcast
        {32'h0000_0049, 32'h2000_0000, 4'b0000}, // R7 no match
        {32'h0000_0842, 32'h0300_0000, 4'b0011}, // R3 flat only
        {32'h0000_0843, 32'h3300_0000, 4'b1111}, // R4 flat and cluster
        {32'h0000_0844, 32'h3200_0000, 4'b1010}, // R4 nibble split
        {32'h0004_0045, 32'h2000_0000, 4'b0010}, // R5 self
        {32'h0008_0046, 32'h2000_0000, 4'b1111}, // R5 all
        {32'h000C_0047, 32'h2000_0000, 4'b1101}, // R5 all but self
        {32'h0000_0150, 32'hFF00_0000, 4'b0001}, // R6 first scan from 0
        {32'h0000_0151, 32'hFF00_0000, 4'b0010}, // R6
        {32'h0000_0152, 32'hFF00_0000, 4'b1000}, // R6 skips disabled
        {32'h0000_0153, 32'hFF00_0000, 4'b0001}, // R6 wrap
        {32'h0000_0154, 32'h1200_0000, 4'b0000}, // R7 only disabled
        {32'h0000_0155, 32'hFF00_0000, 4'b0010}, // R7 pointer kept
        {32'h000C_0156, 32'h2000_0000, 4'b1000}, // R6 with shorthand
        {32'h0000_C45A, 32'h1100_0000, 4'b0010}  // R1 fields
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic write_hi(input logic [31:0] d);
        @(negedge clk);
        cmd_hi_wr = 1'b1;
        wr_data   = d;
        @(negedge clk);
        cmd_hi_wr = 1'b0;
    endtask

    task automatic write_lo(input logic [31:0] d);
        @(negedge clk);
        cmd_lo_wr = 1'b1;
        wr_data   = d;
        @(negedge clk);
        cmd_lo_wr = 1'b0;
    endtask

    // Returns at the fourth negedge after the write is sampled (block idle)
    task automatic run_vec(input logic [31:0] lo, input logic [31:0] hi,
                           input logic [N-1:0] exp_mask, input string req);
        int  lat;
        bit  timing_ok;
        logic [N-1:0] got_mask;
        logic [7:0]   got_vec;
        logic [2:0]   got_mode;
        logic         got_lvl;
        logic         got_trg;
        lat       = (lo[10:8] == 3'b001) ? 3 : 2;
        timing_ok = 1'b1;
        got_mask  = '0;
        got_vec   = '0;
        got_mode  = '0;
        got_lvl   = 1'b0;
        got_trg   = 1'b0;
        write_hi(hi);
        write_lo(lo);
        for (int i = 1; i <= 4; i++) begin
            if (i > 1) @(negedge clk);
            if (dlv_valid !== ((i == lat) && (exp_mask != '0))) timing_ok = 1'b0;
            if (i == lat) begin
                got_mask = dlv_mask;
                got_vec  = dlv_vector;
                got_mode = dlv_mode;
                got_lvl  = dlv_level;
                got_trg  = dlv_trigger;
            end
        end
        check(timing_ok, "R8", "valid pulse timing", 32'(timing_ok), 32'd1);
        check(got_mask === exp_mask, req, "mask", 32'(got_mask), 32'(exp_mask));
        if (exp_mask != '0) begin
            check({got_vec, got_mode, got_lvl, got_trg} ===
                  {lo[7:0], lo[10:8], lo[14], lo[15]},
                  "R1", "fields", {19'h0, got_vec, got_mode, got_lvl, got_trg},
                  {19'h0, lo[7:0], lo[10:8], lo[14], lo[15]});
        end
        check(cmd_lo_rd === (lo & 32'hFFFF_EFFF), "R9", "low readback",
              cmd_lo_rd, lo & 32'hFFFF_EFFF);
        check(cmd_hi_rd === (hi & 32'hFF00_0000), "R9", "high readback",
              cmd_hi_rd, hi & 32'hFF00_0000);
    endtask

    initial begin
        #3_000_000;
        check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state while reset is held and just after release
        check(dlv_valid === 1'b0 && dlv_mask === '0, "R11", "outputs in reset",
              {27'h0, dlv_valid, dlv_mask}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_lo_rd === 32'h0, "R11", "low readback after reset", cmd_lo_rd, 32'h0);
        check(cmd_hi_rd === 32'h0, "R11", "high readback after reset", cmd_hi_rd, 32'h0);
        check(dlv_valid === 1'b0, "R11", "valid after reset", 32'(dlv_valid), 32'd0);

        for (int v = 0; v < NV; v++) begin
            string req;
            req = (v < 3) ? "R2" : (v < 4) ? "R3" : (v < 6) ? "R4" :
                  (v < 9) ? "R5" : (v < 13) ? "R6" : (v < 15) ? "R7" :
                  (v < 16) ? "R6" : "R1";
            run_vec(VEC[v][67:36], VEC[v][35:4], VEC[v][3:0], req);
        end

        // R10: writes during a lowest-priority dispatch; pointer is 3 now
        write_hi(32'hFF00_0000);
        write_lo(32'h0000_0143);
        cmd_lo_wr = 1'b1;               // sampled in MATCH
        wr_data   = 32'h000C_0877;
        @(negedge clk);
        cmd_lo_wr = 1'b0;
        cmd_hi_wr = 1'b1;               // sampled in ARB
        wr_data   = 32'h1100_0000;
        @(negedge clk);
        cmd_hi_wr = 1'b0;
        check(dlv_valid === 1'b1 && dlv_mask === 4'b0001, "R10", "dispatch kept",
              {27'h0, dlv_valid, dlv_mask}, {27'h0, 1'b1, 4'b0001});
        check(dlv_vector === 8'h43, "R10", "vector kept", 32'(dlv_vector), 32'h43);
        cmd_lo_wr = 1'b1;               // sampled in SEND
        wr_data   = 32'h0000_0099;
        @(negedge clk);
        cmd_lo_wr = 1'b0;
        @(negedge clk);
        check(cmd_lo_rd === 32'h0000_0143, "R10", "low readback kept",
              cmd_lo_rd, 32'h0000_0143);
        check(cmd_hi_rd === 32'hFF00_0000, "R10", "high readback kept",
              cmd_hi_rd, 32'hFF00_0000);
        check(dlv_valid === 1'b0, "R10", "no second pulse", 32'(dlv_valid), 32'd0);

        // R5: enable flags ignored outside lowest-priority mode
        tgt_enable = 4'b0000;
        run_vec(32'h0008_0060, 32'h0000_0000, 4'b1111, "R5");
        tgt_enable = 4'b1011;

        finish_run();
    end

endmodule